// File: doc/BRIEF.md
# Averaging Window Alarm Monitor

This block watches a stream of raw sensor readings, each tagged with a channel number. It keeps a separate running average for every channel. Each channel can average over 2, 4, 8 or 16 readings, or pass single readings straight through. A reading can be taken as unsigned or as two's complement, chosen per channel. Each finished average leaves the block on a valid/ready output stream with its channel number. It is also compared against that channel's upper and lower limits. When the average falls outside the window, the channel's alarm flag is set. The flags, masked by per-channel enables, are ORed into one summary alarm line.

One channel, chosen by a parameter, is treated as the temperature channel. It has its own shutdown limit and a sticky shutdown output. This output does not depend on the window alarm or on its enable.

Input back-pressure follows one rule: `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`out_ready` high). A finished average is held on `out_data`/`out_ch` with `out_valid` high, unchanged, until `out_ready` is seen. While the output is stalled no new sample is accepted. Configuration is a plain write port with no handshake; a write takes effect at the next clock edge.

Top module: `amw_monitor`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_ch` hold their values and `in_ready` is low. Otherwise `in_ready` is high, and a sample is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- R2: Depth field (`cfg_field`=0) takes `cfg_wdata[2:0]`. Code 0 passes each sample through; codes 1, 2, 3 and 4 average N = 2, 4, 8 and 16 samples; codes 5 to 7 behave as 4. A channel produces one result for every N samples it accepts, and `out_valid` rises in the cycle after the Nth sample is accepted, never earlier.
- R3: The result is the floor of the sum of the N samples divided by N, truncated to the data width. Mode field (`cfg_field`=1): `cfg_wdata[0]`=1 selects bipolar (two's complement samples, arithmetic shift); 0 selects unipolar (unsigned).
- R4: Upper limit is field 2 and lower limit is field 3. When a channel produces a result, its alarm flag becomes 1 if the result is strictly greater than the upper limit or strictly less than the lower limit, else 0. The compare is signed in bipolar mode and unsigned in unipolar mode. The flag changes only when that channel produces a result.
- R5: Alarm-enable field (`cfg_field`=4, bit 0). `alarm[c]` is the flag of channel c ANDed with its enable, and `alarm_any` is the OR of `alarm`. Clearing an enable hides the flag without losing it.
- R6: Any write to the depth field of a channel clears that channel's partial sum and sample count. A sample on that channel accepted in the same cycle is discarded.
- R7: Shutdown limit is field 5 (`cfg_ch` ignored). A result on the temperature channel that is strictly greater than this limit sets `ot_shutdown`, compared in that channel's mode. It then stays high until reset, independent of the alarm enables.
- R8: After reset `out_valid`, `alarm`, `alarm_any` and `ot_shutdown` are 0 and `in_ready` is 1. Every channel starts at depth code 0, unipolar, upper limit all ones, lower limit 0, alarm enabled. The shutdown limit starts at all ones.
- R9: Channels accumulate independently, so samples of different channels may be interleaved freely. Samples whose channel number is not below the channel count are accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample can be accepted |
| in_ch | input | CH_W | Channel of the sample |
| in_data | input | DATA_W | Raw sample |
| out_valid | output | 1 | Average present |
| out_ready | input | 1 | Consumer takes the average |
| out_ch | output | CH_W | Channel of the average |
| out_data | output | DATA_W | Averaged value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_field | input | 3 | Field selector (0 depth, 1 mode, 2 upper, 3 lower, 4 enable, 5 shutdown limit) |
| cfg_wdata | input | DATA_W | Write data |
| alarm | output | NUM_CH | Enabled per-channel alarm flags |
| alarm_any | output | 1 | OR of the enabled flags |
| ot_shutdown | output | 1 | Sticky over-temperature shutdown |

## Verification
Every cycle, the assertions check several properties. The output holds steady and input is refused during a stall. A new result appears only after an accepted sample. The alarm outputs move only on an accepted sample or a configuration write. The shutdown output never falls, and the output channel is always in range. The numerical behaviour can only be shown by the bench's scenarios. This covers the averages over every depth and both number modes, the strict window edges, the limit compares, partial-sum clearing on a depth write, channel interleaving and the masking of flags by enables.

// File: rtl/amw_pkg.sv
package amw_pkg;

  typedef enum logic [2:0] {
    FLD_DEPTH = 3'd0,
    FLD_MODE  = 3'd1,
    FLD_UPPER = 3'd2,
    FLD_LOWER = 3'd3,
    FLD_ALEN  = 3'd4,
    FLD_OTLIM = 3'd5
  } cfg_field_e;

  localparam int MAX_SHIFT = 4;

  // Depth code to shift amount; codes past the deepest setting saturate.
  function automatic logic [2:0] depth_to_shift(input logic [2:0] code);
    return (code > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : code;
  endfunction

endpackage

// File: rtl/amw_cfg_regs.sv
module amw_cfg_regs
  import amw_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int CH_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [CH_W-1:0]               wch,
  input  logic [2:0]                    wfield,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NUM_CH-1:0][2:0]        shift,
  output logic [NUM_CH-1:0]             bipolar,
  output logic [NUM_CH-1:0][DATA_W-1:0] upper,
  output logic [NUM_CH-1:0][DATA_W-1:0] lower,
  output logic [NUM_CH-1:0]             alarm_en,
  output logic [DATA_W-1:0]             ot_limit,
  output logic [NUM_CH-1:0]             depth_clr
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel          = we && (wch == CH_W'(c));
    assign depth_clr[c] = sel && (wfield == FLD_DEPTH);

    always_ff @(posedge clk) begin
      if (rst) begin
        shift[c]    <= '0;
        bipolar[c]  <= 1'b0;
        upper[c]    <= '1;
        lower[c]    <= '0;
        alarm_en[c] <= 1'b1;
      end else if (sel) begin
        case (wfield)
          FLD_DEPTH: shift[c]    <= depth_to_shift(wdata[2:0]);
          FLD_MODE:  bipolar[c]  <= wdata[0];
          FLD_UPPER: upper[c]    <= wdata;
          FLD_LOWER: lower[c]    <= wdata;
          FLD_ALEN:  alarm_en[c] <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             ot_limit <= '1;
    else if (we && wfield == FLD_OTLIM)  ot_limit <= wdata;
  end

endmodule

// File: rtl/amw_accum.sv
module amw_accum #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int CH_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic [CH_W-1:0]        ch,
  input  logic [DATA_W-1:0]      data,
  input  logic [NUM_CH-1:0][2:0] shift,
  input  logic [NUM_CH-1:0]      bipolar,
  input  logic [NUM_CH-1:0]      clr,
  output logic                   res_valid,
  output logic [DATA_W-1:0]      res_data
);

  localparam int GUARD = 4;
  localparam int ACC_W = DATA_W + GUARD;
  localparam int CNT_W = GUARD;

  logic [NUM_CH-1:0][ACC_W-1:0] acc_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_q;

  logic             ch_ok;
  logic [ACC_W-1:0] acc_sel, ext, sum, shifted;
  logic [CNT_W-1:0] cnt_sel, last_cnt;
  logic [2:0]       sh_sel;
  logic             bip_sel, clr_sel, hit, is_last;

  assign ch_ok = (32'(ch) < NUM_CH);

  always_comb begin
    acc_sel = '0;
    cnt_sel = '0;
    sh_sel  = '0;
    bip_sel = 1'b0;
    clr_sel = 1'b0;
    if (ch_ok) begin
      acc_sel = acc_q[ch];
      cnt_sel = cnt_q[ch];
      sh_sel  = shift[ch];
      bip_sel = bipolar[ch];
      clr_sel = clr[ch];
    end
  end

  assign ext      = bip_sel ? {{GUARD{data[DATA_W-1]}}, data} : {{GUARD{1'b0}}, data};
  assign sum      = acc_sel + ext;
  assign last_cnt = CNT_W'((5'd1 << sh_sel) - 5'd1);
  assign is_last  = (cnt_sel == last_cnt);
  assign shifted  = bip_sel ? ACC_W'($signed(sum) >>> sh_sel) : (sum >> sh_sel);

  assign hit       = take && ch_ok && !clr_sel;
  assign res_valid = hit && is_last;
  assign res_data  = shifted[DATA_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst || clr[c]) begin
        acc_q[c] <= '0;
        cnt_q[c] <= '0;
      end else if (hit && ch == CH_W'(c)) begin
        if (is_last) begin
          acc_q[c] <= '0;
          cnt_q[c] <= '0;
        end else begin
          acc_q[c] <= sum;
          cnt_q[c] <= cnt_q[c] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/amw_window.sv
module amw_window #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] upper,
  input  logic [DATA_W-1:0] lower,
  input  logic              bipolar,
  output logic              above,
  output logic              below
);

  always_comb begin
    if (bipolar) begin
      above = $signed(value) > $signed(upper);
      below = $signed(value) < $signed(lower);
    end else begin
      above = value > upper;
      below = value < lower;
    end
  end

endmodule

// File: rtl/amw_monitor.sv
module amw_monitor
  import amw_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 16,
  parameter int TEMP_CH = 0,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_ch,
  output logic [DATA_W-1:0] out_data,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [2:0]        cfg_field,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [NUM_CH-1:0] alarm,
  output logic              alarm_any,
  output logic              ot_shutdown
);

  logic [NUM_CH-1:0][2:0]        shift;
  logic [NUM_CH-1:0]             bipolar;
  logic [NUM_CH-1:0][DATA_W-1:0] upper;
  logic [NUM_CH-1:0][DATA_W-1:0] lower;
  logic [NUM_CH-1:0]             alarm_en;
  logic [DATA_W-1:0]             ot_limit;
  logic [NUM_CH-1:0]             depth_clr;

  logic              take, res_valid;
  logic [DATA_W-1:0] res_data;
  logic [DATA_W-1:0] up_sel, lo_sel;
  logic              bip_sel;
  logic              win_above, win_below, ot_above, ot_unused;

  logic              out_valid_q;
  logic [CH_W-1:0]   out_ch_q;
  logic [DATA_W-1:0] out_data_q;
  logic [NUM_CH-1:0] flag_q;
  logic              ot_q;

  assign in_ready = !out_valid_q || out_ready;
  assign take     = in_valid && in_ready;

  amw_cfg_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_cfg (
    .clk, .rst,
    .we(cfg_we), .wch(cfg_ch), .wfield(cfg_field), .wdata(cfg_wdata),
    .shift, .bipolar, .upper, .lower, .alarm_en, .ot_limit, .depth_clr
  );

  amw_accum #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_acc (
    .clk, .rst, .take, .ch(in_ch), .data(in_data),
    .shift, .bipolar, .clr(depth_clr),
    .res_valid, .res_data
  );

  // res_valid implies an in-range channel, so the selects are safe when used.
  always_comb begin
    up_sel  = '0;
    lo_sel  = '0;
    bip_sel = 1'b0;
    if (32'(in_ch) < NUM_CH) begin
      up_sel  = upper[in_ch];
      lo_sel  = lower[in_ch];
      bip_sel = bipolar[in_ch];
    end
  end

  amw_window #(.DATA_W(DATA_W)) u_win (
    .value(res_data), .upper(up_sel), .lower(lo_sel), .bipolar(bip_sel),
    .above(win_above), .below(win_below)
  );

  // Shutdown compare: only the upper side matters; lower tied to the value
  // itself so the lower side can never fire.
  amw_window #(.DATA_W(DATA_W)) u_ot (
    .value(res_data), .upper(ot_limit), .lower(res_data), .bipolar(bip_sel),
    .above(ot_above), .below(ot_unused)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_ch_q    <= '0;
      out_data_q  <= '0;
      ot_q        <= 1'b0;
    end else begin
      if (res_valid) begin
        out_valid_q <= 1'b1;
        out_ch_q    <= in_ch;
        out_data_q  <= res_data;
        if (in_ch == CH_W'(TEMP_CH) && ot_above) ot_q <= 1'b1;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                  flag_q[c] <= 1'b0;
      else if (res_valid && in_ch == CH_W'(c))  flag_q[c] <= win_above || win_below;
    end
  end

  assign out_valid   = out_valid_q;
  assign out_ch      = out_ch_q;
  assign out_data    = out_data_q;
  assign alarm       = flag_q & alarm_en;
  assign alarm_any   = |alarm;
  assign ot_shutdown = ot_q;

endmodule

// File: rtl/amw_checker.sv
module amw_checker #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 16,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CH_W-1:0]   out_ch,
  input logic [DATA_W-1:0] out_data,
  input logic              cfg_we,
  input logic [NUM_CH-1:0] alarm,
  input logic              ot_shutdown
);

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ch));

  assert_stall_refuse_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_result_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_alarm_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) && !cfg_we |=> $stable(alarm));

  assert_shutdown_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ot_shutdown |=> ot_shutdown);

  assert_out_ch_range_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (32'(out_ch) < NUM_CH));

endmodule

bind amw_monitor amw_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_amw_checker (
  .clk, .rst, .in_valid, .in_ready, .out_valid, .out_ready,
  .out_ch, .out_data, .cfg_we, .alarm, .ot_shutdown
);

// File: tb/test_amw_monitor.sv
module test_amw_monitor;

  localparam int NUM_CH = 4;
  localparam int DATA_W = 16;
  localparam int CH_W   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [CH_W-1:0]   in_ch = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [CH_W-1:0]   out_ch;
  logic [DATA_W-1:0] out_data;
  logic              cfg_we = 1'b0;
  logic [CH_W-1:0]   cfg_ch = '0;
  logic [2:0]        cfg_field = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [NUM_CH-1:0] alarm;
  logic              alarm_any;
  logic              ot_shutdown;

  int checks = 0;
  int errors = 0;
  logic [NUM_CH-1:0] exp_flag;

  always #5 clk = ~clk;

  amw_monitor #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .TEMP_CH(0)) i_amw_monitor (
    .clk, .rst, .in_valid, .in_ready, .in_ch, .in_data,
    .out_valid, .out_ready, .out_ch, .out_data,
    .cfg_we, .cfg_ch, .cfg_field, .cfg_wdata,
    .alarm, .alarm_any, .ot_shutdown
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_flag = '0;
  endtask

  task automatic cfg(input int ch, input int field, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_field = 3'(field); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Returns at the negedge after the accepting edge; results are visible there.
  task automatic send(input int ch, input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_ch = CH_W'(ch); in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic outside(input logic [DATA_W-1:0] v, input logic [DATA_W-1:0] up,
                                   input logic [DATA_W-1:0] lo, input logic bip);
    if (bip) return ($signed(v) > $signed(up)) || ($signed(v) < $signed(lo));
    return (v > up) || (v < lo);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();

    // R8: reset state
    check("R8 out_valid", 32'(out_valid), 0);
    check("R8 alarm", 32'(alarm), 0);
    check("R8 alarm_any", 32'(alarm_any), 0);
    check("R8 ot_shutdown", 32'(ot_shutdown), 0);
    check("R8 in_ready", 32'(in_ready), 1);
    // R8 defaults: depth 0, unipolar, window [0, FFFF]
    send(1, 16'h1234);
    check("R8 pass-through valid", 32'(out_valid), 1);
    check("R8 pass-through data", 32'(out_data), 32'h1234);
    check("R8 no alarm", 32'(alarm[1]), 0);

    // R2 R3 R4 R5: sweep channels x modes x depths
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int mode = 0; mode < 2; mode++) begin
        logic [DATA_W-1:0] up, lo;
        up = (mode == 1) ? 16'h2000 : 16'h4000;
        lo = (mode == 1) ? 16'hE000 : 16'h1000;
        cfg(ch, 1, 16'(mode));
        cfg(ch, 2, up);
        cfg(ch, 3, lo);
        for (int code = 0; code < 5; code++) begin
          int n;
          longint sum;
          logic [DATA_W-1:0] expv;
          n = 1 << code;
          sum = 0;
          cfg(ch, 0, 16'(code));
          for (int k = 0; k < n; k++) begin
            logic [DATA_W-1:0] v;
            v = 16'(((ch * 4001 + k * 7919 + code * 1237 + mode * 555) * 37) & 16'hFFFF);
            if (k == n - 1 && (code & 1) == 1) v = 16'h1800 + 16'(k);
            sum += (mode == 1) ? longint'($signed(v)) : longint'(v);
            send(ch, v);
            if (k < n - 1) check("R2 no early result", 32'(out_valid), 0);
          end
          expv = 16'(sum >>> code);
          exp_flag[ch] = outside(expv, up, lo, mode[0]);
          check("R2 result valid", 32'(out_valid), 1);
          check("R3 average", 32'(out_data), 32'(expv));
          check("R9 out_ch", 32'(out_ch), 32'(ch));
          check("R4 window flag", 32'(alarm[ch]), 32'(exp_flag[ch]));
          check("R5 alarm_any", 32'(alarm_any), 32'(|exp_flag));
        end
      end
    end

    // R9: interleaved channels at depth 2
    do_reset();
    cfg(0, 0, 16'd1);
    cfg(1, 0, 16'd1);
    send(0, 16'd100);
    send(1, 16'd7);
    check("R9 no result ch1 after one", 32'(out_valid), 0);
    send(0, 16'd301);
    check("R9 ch0 avg", 32'(out_data), 32'd200);
    check("R9 ch0 tag", 32'(out_ch), 0);
    send(1, 16'd10);
    check("R9 ch1 avg", 32'(out_data), 32'd8);
    check("R9 ch1 tag", 32'(out_ch), 1);
    // R9: out-of-range channel is not possible with 4 channels and 2 bits; ensure nothing leaks
    check("R9 alarm clear", 32'(alarm), 0);

    // R4: strict window edges, set and clear
    do_reset();
    cfg(2, 2, 16'h0200);
    cfg(2, 3, 16'h0100);
    send(2, 16'h0300); check("R4 above sets", 32'(alarm[2]), 1);
    send(2, 16'h0150); check("R4 inside clears", 32'(alarm[2]), 0);
    send(2, 16'h0050); check("R4 below sets", 32'(alarm[2]), 1);
    send(2, 16'h0200); check("R4 equal upper inside", 32'(alarm[2]), 0);
    send(2, 16'h0100); check("R4 equal lower inside", 32'(alarm[2]), 0);
    send(2, 16'hFFF0); check("R4 unsigned large above", 32'(alarm[2]), 1);
    cfg(2, 1, 16'd1);
    cfg(2, 3, 16'hFFF0);
    send(2, 16'hFFF0); check("R4 signed equal lower inside", 32'(alarm[2]), 0);
    send(2, 16'hFFEF); check("R4 signed below sets", 32'(alarm[2]), 1);
    send(3, 16'h0000);
    check("R4 other channel keeps flag", 32'(alarm[2]), 1);

    // R5: enable masks without losing the flag
    cfg(2, 4, 16'd0);
    check("R5 masked alarm", 32'(alarm[2]), 0);
    check("R5 masked any", 32'(alarm_any), 0);
    cfg(2, 4, 16'd1);
    check("R5 flag retained", 32'(alarm[2]), 1);
    check("R5 any restored", 32'(alarm_any), 1);

    // R6: depth write clears partial sum
    do_reset();
    cfg(3, 0, 16'd2);
    send(3, 16'h1000);
    send(3, 16'h1000);
    send(3, 16'h1000);
    cfg(3, 0, 16'd1);
    send(3, 16'd40);
    check("R6 restart no result", 32'(out_valid), 0);
    send(3, 16'd60);
    check("R6 fresh average valid", 32'(out_valid), 1);
    check("R6 fresh average", 32'(out_data), 32'd50);
    // R6: sample in the same cycle as a depth write is dropped
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'd3; cfg_field = 3'd0; cfg_wdata = 16'd0;
    in_valid = 1'b1; in_ch = 2'd3; in_data = 16'hBEEF;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R6 same-cycle sample dropped", 32'(out_valid), 0);
    // R2: codes above 4 behave as 16
    cfg(3, 0, 16'd7);
    for (int k = 0; k < 16; k++) begin
      send(3, 16'(k * 2));
      if (k < 15) check("R2 saturated depth no early", 32'(out_valid), 0);
    end
    check("R2 saturated depth avg", 32'(out_data), 32'd15);

    // R1: back-pressure
    do_reset();
    out_ready = 1'b0;
    send(1, 16'hAAAA);
    check("R1 result valid", 32'(out_valid), 1);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 2'd1; in_data = 16'h5555;
    repeat (3) begin
      @(negedge clk);
      check("R1 held valid", 32'(out_valid), 1);
      check("R1 held data", 32'(out_data), 32'hAAAA);
      check("R1 input refused", 32'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next result", 32'(out_data), 32'h5555);
    check("R1 next valid", 32'(out_valid), 1);
    @(negedge clk);
    check("R1 drained", 32'(out_valid), 0);

    // R7: over-temperature shutdown on channel 0
    do_reset();
    cfg(0, 5, 16'h8000);
    send(1, 16'hFFFF);
    check("R7 other channel ignored", 32'(ot_shutdown), 0);
    send(0, 16'h8000);
    check("R7 equal not over", 32'(ot_shutdown), 0);
    send(0, 16'h8001);
    check("R7 over sets", 32'(ot_shutdown), 1);
    send(0, 16'h0000);
    check("R7 sticky", 32'(ot_shutdown), 1);
    cfg(0, 4, 16'd0);
    check("R7 independent of enable", 32'(ot_shutdown), 1);
    do_reset();
    check("R7 cleared by reset", 32'(ot_shutdown), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule